// File: doc/BRIEF.md
# Hierarchical 64-bit Magnitude Comparator

This block compares two unsigned operands and reports whether the first is below, equal to, or above the second. It is purely combinational: there is no clock and no reset, so the three flags follow the operands directly. It fits wherever a datapath needs a fast ordering decision, such as a bounds check, a sort step or a timer match.

The operands are cut into equal slices. Inside each slice a per-bit "below" term and a per-bit "same" term are merged pairwise up a small binary tree, in the way carry-lookahead logic merges generate and propagate. The slice results then feed a flat priority network rather than further tree levels. For every slice except the top one, that slice's "below" flag is qualified by the "same" flags of all the slices above it. The final "below" flag is the OR of these terms and the top slice's own "below" flag. The final "equal" flag is the AND of all the slice "same" flags. The "above" flag is high only when the other two are both low.

Top module: `mag_cmp64`

## Requirements
- R1: `lt` is 1 exactly when `a` is less than `b` as unsigned numbers, and 0 otherwise.
- R2: `eq` is 1 exactly when `a` and `b` are identical in every bit, and 0 otherwise.
- R3: `gt` is 1 exactly when both `lt` and `eq` are 0, which is exactly when `a` is greater than `b` as unsigned numbers.
- R4: For any pair of operands, exactly one of `lt`, `eq` and `gt` is 1.
- R5: When the operands differ only in bit 0, that bit alone decides the result: `lt`=1 if `a[0]`=0 and `b[0]`=1, otherwise `gt`=1.
- R6: When the operands differ in bit 63, that bit decides the result whatever the lower 63 bits hold.
- R7: The operands form eight 8-bit slices, with slice k covering bits 8k+7 down to 8k. When every slice above slice k is equal and slice k differs, slice k decides the result and all lower slices have no effect, even when they favour the other operand.
- R8: Within a slice, the most significant differing bit decides the result and the lower bits of that slice have no effect.
- R9: The outputs follow a change of the operands without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First unsigned operand |
| b | input | 64 | Second unsigned operand |
| lt | output | 1 | High when a < b |
| eq | output | 1 | High when a == b |
| gt | output | 1 | High when a > b |

## Verification
Random operands almost always differ in their top slice. As a result, the merge terms that qualify a lower slice by the equality of every slice above it are practically never exercised. To reach them, the bench builds pairs whose upper slices are copied exactly. It places a single deciding difference at a chosen slice or bit position, then fills everything below that point so that it favours the opposite operand. A wrongly wired qualifier or priority term then flips the answer. The bench does this at every slice boundary and at every bit position of one slice.

// File: rtl/mag_cmp64.sv
module mag_cmp64 #(
  parameter int SLICE_W  = 8,
  parameter int N_SLICES = 8
) (
  input  logic [SLICE_W*N_SLICES-1:0] a,
  input  logic [SLICE_W*N_SLICES-1:0] b,
  output logic                        lt,
  output logic                        eq,
  output logic                        gt
);
  localparam int WIDTH = SLICE_W * N_SLICES;
  localparam int NODES = 2 * SLICE_W;

  logic [N_SLICES-1:0] sl_lt;
  logic [N_SLICES-1:0] sl_eq;
  logic [N_SLICES-2:0] qual_lt;

  genvar s, n, k;
  generate
    for (s = 0; s < N_SLICES; s++) begin : g_slice
      // heap layout: node 1 is the root, leaf for bit i sits at SLICE_W+i,
      // node m merges children 2m+1 (upper half) and 2m (lower half)
      logic [NODES-1:1] t_lt;
      logic [NODES-1:1] t_eq;
      logic [SLICE_W-1:0] sa, sb;

      assign sa = a[s*SLICE_W +: SLICE_W];
      assign sb = b[s*SLICE_W +: SLICE_W];
      assign t_lt[NODES-1:SLICE_W] = ~sa & sb;
      assign t_eq[NODES-1:SLICE_W] = ~(sa ^ sb);

      for (n = 1; n < SLICE_W; n++) begin : g_node
        assign t_lt[n] = t_lt[2*n+1] | (t_eq[2*n+1] & t_lt[2*n]);
        assign t_eq[n] = t_eq[2*n+1] & t_eq[2*n];
      end

      assign sl_lt[s] = t_lt[1];
      assign sl_eq[s] = t_eq[1];

      always_comb begin
        assert_slice_excl_R7: assert (!(sl_lt[s] && sl_eq[s]))
          else $error("slice %0d reports below and equal together", s);
        assert_slice_eq_R8: assert (sl_eq[s] == (sa == sb))
          else $error("slice %0d equality term wrong", s);
      end
    end

    for (k = 0; k < N_SLICES-1; k++) begin : g_qual
      assign qual_lt[k] = sl_lt[k] & (&sl_eq[N_SLICES-1:k+1]);
    end
  endgenerate

  assign lt = sl_lt[N_SLICES-1] | (|qual_lt);
  assign eq = &sl_eq;
  assign gt = ~(lt | eq);

  always_comb begin
    assert_lt_match_R1: assert (lt == (a < b))
      else $error("lt disagrees with unsigned ordering");
    assert_eq_match_R2: assert (eq == (a == b))
      else $error("eq disagrees with operand equality");
    assert_gt_match_R3: assert (gt == (a > b))
      else $error("gt disagrees with unsigned ordering");
    assert_one_hot_R4: assert ($countones({lt, eq, gt}) == 1)
      else $error("result flags are not one-hot");
  end

  logic unused_width;
  assign unused_width = (WIDTH == 0);
endmodule

// File: tb/tb_mag_cmp64.sv
module tb_mag_cmp64;
  logic        clk = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        lt, eq, gt;
  int          n_checks = 0;
  int          n_fail   = 0;
  bit          done     = 1'b0;

  always #4 clk = ~clk;

  mag_cmp64 dut (.a(a), .b(b), .lt(lt), .eq(eq), .gt(gt));

  task automatic check_pair(input logic [63:0] va, input logic [63:0] vb,
                            input string tag);
    logic elt, eeq, egt;
    a = va;
    b = vb;
    #1;
    elt = (va < vb);
    eeq = (va == vb);
    egt = (va > vb);
    n_checks++;
    if ({lt, eq, gt} !== {elt, eeq, egt}) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h lt/eq/gt actual=%b%b%b expected=%b%b%b",
               tag, va, vb, lt, eq, gt, elt, eeq, egt);
    end
    n_checks++;
    if ($countones({lt, eq, gt}) != 1) begin
      n_fail++;
      $display("FAIL R4 a=%h b=%h onehot actual=%b%b%b expected one bit set",
               va, vb, lt, eq, gt);
    end
  endtask

  task automatic t_zero();
    @(negedge clk);
    check_pair(64'h0, 64'h0, "R2 zero operands");
  endtask

  task automatic t_equal();
    logic [63:0] v;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      v = {$urandom, $urandom};
      check_pair(v, v, "R2 equal operands");
    end
    check_pair(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R2 all ones equal");
  endtask

  task automatic t_extremes();
    @(negedge clk);
    check_pair(64'h0, 64'hFFFF_FFFF_FFFF_FFFF, "R1 zeros vs ones");
    check_pair(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, "R3 ones vs zeros");
  endtask

  task automatic t_bit0();
    logic [63:0] v;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      v = {$urandom, $urandom} & ~64'h1;
      check_pair(v, v | 64'h1, "R5 bit0 a<b");
      check_pair(v | 64'h1, v, "R5 bit0 a>b");
    end
  endtask

  task automatic t_bit63();
    logic [62:0] x, y;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      x = 63'({$urandom, $urandom});
      y = 63'({$urandom, $urandom});
      check_pair({1'b0, x}, {1'b1, y}, "R6 bit63 a<b");
      check_pair({1'b1, x}, {1'b0, y}, "R6 bit63 a>b");
    end
    check_pair({1'b0, {63{1'b1}}}, {1'b1, 63'h0}, "R6 bit63 lower all opposing");
  endtask

  task automatic t_slices();
    logic [63:0] base, va, vb, low;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      base = {$urandom, $urandom};
      low  = (64'h1 << (8*k)) - 64'h1;
      va = (base & ~(64'hFF << (8*k)) & ~low);
      vb = va | (64'h1 << (8*k));
      va = va | low;
      check_pair(va, vb, $sformatf("R7 slice %0d decides a<b", k));
      check_pair(vb, va, $sformatf("R7 slice %0d decides a>b", k));
      if (k > 0) begin
        va = base & ~(64'h1 << (8*k - 1));
        vb = va | (64'h1 << (8*k - 1));
        check_pair(va, vb, $sformatf("R7 top bit below slice %0d", k));
      end
    end
  endtask

  task automatic t_in_slice();
    logic [63:0] base, va, vb;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      base = {$urandom, $urandom} & ~(64'hFF << 24);
      va = base | (((64'h1 << j) - 64'h1) << 24);
      vb = base | (64'h1 << (24 + j));
      check_pair(va, vb, $sformatf("R8 slice3 bit %0d decides a<b", j));
      check_pair(vb, va, $sformatf("R8 slice3 bit %0d decides a>b", j));
    end
  endtask

  task automatic t_no_clock();
    // R9: several operand changes within one clock phase, each sampled 1 ns later
    @(negedge clk);
    check_pair(64'h10, 64'h20, "R9 comb a<b");
    check_pair(64'h20, 64'h20, "R9 comb a=b");
    check_pair(64'h30, 64'h20, "R9 comb a>b");
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      check_pair({$urandom, $urandom}, {$urandom, $urandom}, "R1 R3 random");
    end
  endtask

  initial begin
    t_zero();
    t_equal();
    t_extremes();
    t_bit0();
    t_bit63();
    t_slices();
    t_in_slice();
    t_no_clock();
    t_random();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule